// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobes

This block presents a five-digit BCD reading on a shared 4-bit bus, one digit at a time. A one-hot set of digit drive lines shows which digit is on the bus. It also sends one burst of active-low transfer strobes for each completed measurement. Each strobe sits in the middle of its digit window, so an external latch can capture the BCD value while both the bus and the drive are stable. Another block produces the digit values and holds them stable; this block only chooses which digit to show and when to strobe.

A single-cycle end-of-measurement event starts a scan at the most significant digit. That first window is one count longer than the others. The scan then steps down to the least significant digit and wraps back to the top, and it keeps cycling for as long as the block is clocked. Only the first pass after each event carries strobes. Later passes show the digits without strobes until the next event arrives. An overrange reading does not stop or change the scan.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While reset is asserted and after its release, until the first end-of-measurement event, all digit drives are low, the BCD bus is 0 and the strobe output is high.
- R2: When `meas_done` is high at a rising clock edge, `digit_en[4]` (most significant digit) is active from the next cycle for exactly 201 cycles.
- R3: After the most significant window, `digit_en[3]`, `digit_en[2]`, `digit_en[1]` and `digit_en[0]` follow in that order, each for 200 cycles. The scan then returns to `digit_en[4]` for 201 cycles and repeats, a period of 1001 cycles.
- R4: At most one digit drive is ever high, and once scanning has started exactly one is high in every cycle.
- R5: The BCD bus carries `digits[4k+3:4k]` while `digit_en[k]` is high, so `digits[19:16]` is the most significant digit.
- R6: A strobe is low only during the low phase of the clock, that is half a clock period, in the 101st cycle of a digit window (offset 100 from the window's first cycle). The first strobe therefore falls in the 101st cycle after the end-of-measurement event.
- R7: Each end-of-measurement event yields exactly five strobes, one per digit from the most significant down to the least significant. After that no strobe is sent while scanning continues, until the next event.
- R8: An end-of-measurement event in the middle of a scan restarts the scan at the most significant digit with a full 201-cycle window and re-arms a full burst of five strobes.
- R9: `overrange` has no effect on the digit drives, the BCD bus or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_done | input | 1 | Single-cycle end-of-measurement event |
| digits | input | 20 | Latched reading, five BCD digits, most significant in bits 19:16 |
| overrange | input | 1 | Reading exceeds range; scanning is unaffected |
| digit_en | output | 5 | One-hot digit drives, bit 4 most significant |
| bcd | output | 4 | BCD value of the currently driven digit |
| strobe_n | output | 1 | Active-low half-clock transfer strobe |

## Verification
The hardest case to reach is the end of a strobe burst: the scan keeps running after the fifth strobe, and the bench must see that strobes stop while the drives carry on. A further end-of-measurement event arriving part way through a window must re-arm the burst cleanly. The stimulus therefore runs past two full 1001-cycle periods after an event, then fires a new event in the middle of a later digit window, away from that window's strobe cycle. Each strobe is sampled in both clock phases, so a strobe that lasts a whole cycle, or that falls in the wrong half of the cycle, is caught. Overrange is toggled during a whole scan to show that the outputs ignore it.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
    localparam int DEF_DIGITS  = 5;
    localparam int DEF_BCD_W   = 4;
    localparam int DEF_WIN     = 200;
    localparam int DEF_STB_OFS = 100;

    typedef struct packed {
        logic armed;
    } strobe_st_t;
endpackage

// File: rtl/bcd_scan_timer.sv
module bcd_scan_timer #(
    parameter int DIGITS  = bcd_scan_pkg::DEF_DIGITS,
    parameter int WIN     = bcd_scan_pkg::DEF_WIN,
    parameter int IDX_W   = $clog2(DIGITS),
    parameter int CNT_W   = $clog2(WIN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [IDX_W-1:0] MSD_IDX  = IDX_W'(DIGITS - 1);
    localparam logic [CNT_W-1:0] LAST_MSD = CNT_W'(WIN);
    localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(WIN - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d   = st_q;
        last_d = (st_q.idx == MSD_IDX) ? LAST_MSD : LAST_STD;
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = MSD_IDX;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == last_d) begin
                st_d.cnt = '0;
                st_d.idx = (st_q.idx == '0) ? MSD_IDX : st_q.idx - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign idx    = st_q.idx;
    assign cnt    = st_q.cnt;

    // R2: a window never runs past the long first-digit length
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= LAST_MSD));

    // R8: an event always lands on the first cycle of the top digit
    a_r8_restart_msd: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && idx == MSD_IDX && cnt == '0));

    // R3: the index stays within the digit range
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= MSD_IDX));
endmodule

// File: rtl/bcd_strobe_gen.sv
module bcd_strobe_gen #(
    parameter int STB_OFS = bcd_scan_pkg::DEF_STB_OFS,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] cnt,
    output logic             strobe_n
);
    import bcd_scan_pkg::*;

    localparam logic [CNT_W-1:0] MID = CNT_W'(STB_OFS);

    strobe_st_t st_d, st_q;
    logic fire;
    logic last_digit;

    assign last_digit = (idx == '0);
    assign fire       = st_q.armed && active && (cnt == MID);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.armed = 1'b1;
        end else if (fire && last_digit) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Low only in the second half of the firing cycle
    assign strobe_n = ~(fire & ~clk);

    // R6: a strobe occupies a single count
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R7: the burst closes after the least significant digit
    a_r7_burst_close: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_digit && !start) |=> !st_q.armed);
endmodule

// File: rtl/bcd_digit_mux.sv
module bcd_digit_mux #(
    parameter int DIGITS = bcd_scan_pkg::DEF_DIGITS,
    parameter int BCD_W  = bcd_scan_pkg::DEF_BCD_W,
    parameter int IDX_W  = $clog2(DIGITS)
) (
    input  logic [DIGITS*BCD_W-1:0] digits,
    input  logic                    active,
    input  logic [IDX_W-1:0]        idx,
    output logic [DIGITS-1:0]       digit_en,
    output logic [BCD_W-1:0]        bcd
);
    logic [BCD_W-1:0] slice [DIGITS];
    logic [DIGITS-1:0] hit;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign slice[g] = digits[g*BCD_W +: BCD_W];
        assign hit[g]   = active && (idx == IDX_W'(g));
    end

    always_comb begin
        bcd = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (hit[i]) begin
                bcd = slice[i];
            end
        end
    end

    assign digit_en = hit;
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
    parameter int DIGITS  = bcd_scan_pkg::DEF_DIGITS,
    parameter int BCD_W   = bcd_scan_pkg::DEF_BCD_W,
    parameter int WIN     = bcd_scan_pkg::DEF_WIN,
    parameter int STB_OFS = bcd_scan_pkg::DEF_STB_OFS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_done,
    input  logic [DIGITS*BCD_W-1:0] digits,
    input  logic                    overrange,
    output logic [DIGITS-1:0]       digit_en,
    output logic [BCD_W-1:0]        bcd,
    output logic                    strobe_n
);
    localparam int IDX_W = $clog2(DIGITS);
    localparam int CNT_W = $clog2(WIN + 2);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;

    bcd_scan_timer #(
        .DIGITS(DIGITS), .WIN(WIN), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(meas_done),
        .active(active), .idx(idx), .cnt(cnt)
    );

    bcd_strobe_gen #(
        .STB_OFS(STB_OFS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(meas_done),
        .active(active), .idx(idx), .cnt(cnt), .strobe_n(strobe_n)
    );

    bcd_digit_mux #(
        .DIGITS(DIGITS), .BCD_W(BCD_W), .IDX_W(IDX_W)
    ) u_mux (
        .digits(digits), .active(active), .idx(idx),
        .digit_en(digit_en), .bcd(bcd)
    );

    // R4: never more than one drive
    a_r4_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_en));

    // R4: once started, a drive is always on
    a_r4_always_one: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> $onehot(digit_en));

    // R9: an overrange reading still starts the scan at the top digit
    a_r9_overrange_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && overrange) |=> digit_en[DIGITS-1]);
endmodule

// File: tb/bcd_digit_scanner_tb_top.sv
`timescale 1ns/1ps
module bcd_digit_scanner_tb_top;
    localparam int PERIOD = 1001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_done = 1'b0;
    logic [19:0] digits = '0;
    logic        overrange = 1'b0;
    logic [4:0]  digit_en;
    logic [3:0]  bcd;
    logic        strobe_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    bit run = 0;
    int t = 0;
    int left = 0;
    bit fire_exp = 0;
    int obs_strobes = 0;

    always #5 clk = ~clk;

    bcd_digit_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .meas_done(meas_done), .digits(digits),
        .overrange(overrange), .digit_en(digit_en), .bcd(bcd), .strobe_n(strobe_n)
    );

    function automatic int exp_k(int tt);
        if (tt < 201) return 4;
        return 3 - (tt - 201) / 200;
    endfunction

    function automatic int exp_off(int tt);
        if (tt < 201) return tt;
        return (tt - 201) % 200;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0; t = 0; left = 0;
        end else if (meas_done) begin
            run = 1; t = 0; left = 5;
        end else begin
            if (fire_exp) left--;
            if (run) t = (t + 1) % PERIOD;
        end
        fire_exp = run && (left > 0) && (exp_off(t) == 100);
    end

    // high-phase check: strobe never low while clk is high (R6)
    always @(posedge clk) begin
        #1;
        if (!done) check(strobe_n === 1'b1, "R6 high-phase", strobe_n, 1);
    end

    // low-phase comparison of all outputs
    always @(negedge clk) begin
        #2;
        if (!done) begin
            logic [4:0] e_en;
            logic [3:0] e_bcd;
            string tg;
            e_en  = run ? (5'b1 << exp_k(t)) : 5'b0;
            e_bcd = run ? digits[exp_k(t)*4 +: 4] : 4'h0;
            if (!run) tg = "R1";
            else if (overrange) tg = "R9";
            else if (exp_k(t) == 4) tg = "R2";
            else tg = "R3";
            check(digit_en === e_en, tg, digit_en, e_en);
            check($countones(digit_en) == (run ? 1 : 0), "R4", digit_en, e_en);
            check(bcd === e_bcd, overrange ? "R9" : "R5", bcd, e_bcd);
            check(strobe_n === !fire_exp, overrange ? "R9" : "R6", strobe_n, !fire_exp);
            if (strobe_n === 1'b0) obs_strobes++;
        end
    end

    task automatic pulse_done();
        @(posedge clk); #3;
        meas_done = 1'b1;
        @(posedge clk); #3;
        meas_done = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        // R1: reset state
        #2;
        check(digit_en === 5'b0, "R1", digit_en, 0);
        check(strobe_n === 1'b1, "R1", strobe_n, 1);
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        wait_cycles(50);

        // first burst, two and a bit periods
        digits = 20'h19876;
        obs_strobes = 0;
        pulse_done();
        wait_cycles(700);
        digits = 20'h05432;          // R5: bus follows live digits
        wait_cycles(1600);
        check(obs_strobes == 5, "R7 burst count", obs_strobes, 5);

        // R8: restart in the middle of a digit window, away from strobe
        wait_cycles(437);
        obs_strobes = 0;
        pulse_done();
        check(digit_en === 5'b10000, "R8 restart msd", digit_en, 5'b10000);
        wait_cycles(1500);
        check(obs_strobes == 5, "R8 rearmed burst", obs_strobes, 5);

        // restart just after a strobe inside a burst
        wait_cycles(1);
        obs_strobes = 0;
        pulse_done();
        wait_cycles(100);
        pulse_done();
        obs_strobes = 0;
        wait_cycles(1200);
        check(obs_strobes == 5, "R8 restart mid-burst", obs_strobes, 5);

        // R9: overrange toggling during a full scan
        digits = 20'h20000;
        overrange = 1'b1;
        obs_strobes = 0;
        pulse_done();
        for (int i = 0; i < 24; i++) begin
            wait_cycles(53);
            overrange = ~overrange;
        end
        wait_cycles(900);
        check(obs_strobes == 5, "R9 strobes", obs_strobes, 5);
        overrange = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule